// File: doc/BRIEF.md
# Dual-Bank Direct Digital Synthesis Waveform Core

The block is a direct digital synthesis engine that runs on a single master clock and produces a digital code for an external DAC. A 28-bit phase accumulator grows by a frequency word on every master clock, so the output frequency is fclk × word / 2^28. The top 12 bits of the accumulator, plus a 12-bit phase offset, form a phase value. That phase value drives one of three shapers: a sine (through a quarter-wave table computed at elaboration), a folded triangle, or a square. Each result is a 10-bit code.

Two frequency words and two phase words are held in a small register bank that has its own write ports. Two select inputs choose which frequency word and which phase word are active. The hold input parks the waveform at its starting point but leaves the stored words alone, so a new setting can be prepared while the output is quiet. Every setting takes effect after a fixed latency of 8 clocks, counted from the clock edge that samples it.

Top module: `dds_core`

## Requirements
- R1: While `rst_n` is low, `dac_code` is mid-scale (512), and both banks, the selects and the accumulator are cleared to zero.
- R2: On every clock edge where the synchronised hold is inactive, the accumulator advances by the selected frequency word modulo 2^28.
- R3: A write with `wr_freq_en` or `wr_phase_en` high stores the word in slot `*_idx` (0 or 1). `freq_sel` and `phase_sel` pick the active slot.
- R4: The phase value is accumulator bits [27:16] plus the selected phase word, modulo 4096.
- R5: While `wave_hold` is applied, the accumulator is cleared and the phase value is forced to 0, so the output shows the start code (sine 512, triangle 0, square 0). The stored words are not changed by hold, and the output resumes from them when hold is released.
- R6: A change to any word, select, mode or hold that is sampled at clock edge k appears on `dac_code` after edge k+8. This applies equally to a frequency write, a phase write and a hold release.
- R7: When `wave_mode` = 00 (sine), the code is 512 ± round(511·|sin(2π(t+0.5)/4096)|) for phase value t. The sign is + for t < 2048 and − for t ≥ 2048.
- R8: When `wave_mode` = 01 (triangle), the code is t[10:1] for t < 2048 and the bitwise inverse of t[10:1] otherwise.
- R9: When `wave_mode` = 1x (square), the code is 1023 when t[11] is 1 and 0 when t[11] is 0.
- R10: With a frequency word of 0, the output is constant.
- R11: Frequency words up to 2^28−1 wrap the accumulator and step the phase backwards without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| wave_hold | input | 1 | Park waveform at start, registers kept |
| wr_freq_en | input | 1 | Frequency word write strobe |
| wr_freq_idx | input | 1 | Frequency slot to write |
| wr_freq_word | input | 28 | Frequency word to store |
| wr_phase_en | input | 1 | Phase word write strobe |
| wr_phase_idx | input | 1 | Phase slot to write |
| wr_phase_word | input | 12 | Phase word to store |
| freq_sel | input | 1 | Active frequency slot |
| phase_sel | input | 1 | Active phase slot |
| wave_mode | input | 2 | 00 sine, 01 triangle, 1x square |
| dac_code | output | 10 | Digital amplitude code for the DAC |

## Verification
The bench builds the core at its default widths: a 28-bit accumulator, a 12-bit phase and a 10-bit code. With these widths a frequency word of 2^20 walks through every quadrant of the sine table in 256 clocks, and words near 2^28 make the accumulator wrap on every step. A reference model that delays its results by eight clocks is compared with the output on every cycle. Separate cycle counts measure the latency after a phase write, after a select change and after a hold release.

// File: rtl/dds_pkg.sv
package dds_pkg;

  typedef enum logic [1:0] {
    WAVE_SINE = 2'd0,
    WAVE_TRI  = 2'd1,
    WAVE_SQR  = 2'd2,
    WAVE_SQR2 = 2'd3
  } wave_e;

  // Magnitude of one quarter-wave sample, taken at the centre of its phase bin.
  function automatic int quarter_amp(int idx, int qbits, int abits);
    real step;
    real ang;
    real peak;
    step = 6.283185307179586 / real'(4 << qbits);
    ang  = step * (real'(idx) + 0.5);
    peak = real'((1 << (abits - 1)) - 1);
    return $rtoi(peak * $sin(ang) + 0.5);
  endfunction

endpackage

// File: rtl/dds_regbank.sv
module dds_regbank #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12,
  parameter int SLOTS = 2,
  localparam int SEL_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_freq_en,
  input  logic [SEL_W-1:0]            wr_freq_idx,
  input  logic [ACC_W-1:0]            wr_freq_word,
  input  logic                        wr_phase_en,
  input  logic [SEL_W-1:0]            wr_phase_idx,
  input  logic [PH_W-1:0]             wr_phase_word,
  input  logic [SEL_W-1:0]            freq_sel,
  input  logic [SEL_W-1:0]            phase_sel,
  output logic [SLOTS-1:0][ACC_W-1:0] freq_bank,
  output logic [SLOTS-1:0][PH_W-1:0]  phase_bank,
  output logic [ACC_W-1:0]            freq_act,
  output logic [PH_W-1:0]             phase_act
);

  logic [SEL_W-1:0] fsel_q;
  logic [SEL_W-1:0] psel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_bank  <= '0;
      phase_bank <= '0;
      fsel_q     <= '0;
      psel_q     <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (wr_freq_en && (wr_freq_idx == SEL_W'(i)))
          freq_bank[i] <= wr_freq_word;
        if (wr_phase_en && (wr_phase_idx == SEL_W'(i)))
          phase_bank[i] <= wr_phase_word;
      end
      fsel_q <= freq_sel;
      psel_q <= phase_sel;
    end
  end

  assign freq_act  = freq_bank[fsel_q];
  assign phase_act = phase_bank[psel_q];

endmodule

// File: rtl/dds_accum.sv
module dds_accum
  import dds_pkg::*;
#(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_req,
  input  logic [ACC_W-1:0] freq_act,
  input  logic [PH_W-1:0]  phase_act,
  input  wave_e            mode_in,
  output logic [ACC_W-1:0] acc_q,
  output logic [PH_W-1:0]  theta_q,
  output wave_e            mode_out,
  output logic             hold_sync
);

  localparam int MODE_DLY = 3;

  logic             hold_s1;
  logic             hold_s2;
  logic [PH_W-1:0]  phase_q;
  wave_e            mode_dly [MODE_DLY];

  function automatic logic [ACC_W-1:0] acc_step(input logic [ACC_W-1:0] cur,
                                                input logic [ACC_W-1:0] inc);
    return cur + inc;
  endfunction

  function automatic logic [PH_W-1:0] phase_point(input logic [ACC_W-1:0] cur,
                                                  input logic [PH_W-1:0]  ofs);
    return cur[ACC_W-1 -: PH_W] + ofs;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_s1 <= 1'b1;
      hold_s2 <= 1'b1;
      acc_q   <= '0;
      phase_q <= '0;
      theta_q <= '0;
      for (int i = 0; i < MODE_DLY; i++) mode_dly[i] <= WAVE_SINE;
    end else begin
      hold_s1 <= hold_req;
      hold_s2 <= hold_s1;
      acc_q   <= hold_s2 ? '0 : acc_step(acc_q, freq_act);
      phase_q <= phase_act;
      theta_q <= hold_s2 ? '0 : phase_point(acc_q, phase_q);
      mode_dly[0] <= mode_in;
      for (int i = 1; i < MODE_DLY; i++) mode_dly[i] <= mode_dly[i-1];
    end
  end

  assign hold_sync = hold_s2;
  assign mode_out  = mode_dly[MODE_DLY-1];

endmodule

// File: rtl/dds_shaper.sv
module dds_shaper
  import dds_pkg::*;
#(
  parameter int PH_W  = 12,
  parameter int AMP_W = 10,
  parameter int TAIL  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PH_W-1:0]  theta,
  input  wave_e            mode,
  output logic [AMP_W-1:0] dac_code
);

  localparam int QB = PH_W - 2;
  localparam int QN = 1 << QB;
  localparam logic [AMP_W-1:0] MID_C = {1'b1, {(AMP_W-1){1'b0}}};

  logic [AMP_W-2:0] qtab [QN];

  for (genvar gi = 0; gi < QN; gi++) begin : g_qrom
    localparam int QV = quarter_amp(gi, QB, AMP_W);
    assign qtab[gi] = QV[AMP_W-2:0];
  end

  function automatic logic [AMP_W-1:0] tri_fold(input logic [PH_W-1:0] t);
    return t[PH_W-1] ? ~t[PH_W-2 -: AMP_W] : t[PH_W-2 -: AMP_W];
  endfunction

  function automatic logic [AMP_W-1:0] sine_join(input logic lower,
                                                 input logic [AMP_W-2:0] mag);
    return lower ? (MID_C - {1'b0, mag}) : (MID_C + {1'b0, mag});
  endfunction

  logic [QB-1:0]            q_idx;
  logic [AMP_W-2:0]         q_mag;
  logic [AMP_W-1:0]         shape_d;
  logic [TAIL:0][AMP_W-1:0] pipe;

  always_comb begin
    q_idx = theta[PH_W-2] ? ~theta[QB-1:0] : theta[QB-1:0];
    q_mag = qtab[q_idx];
    case (mode)
      WAVE_SINE: shape_d = sine_join(theta[PH_W-1], q_mag);
      WAVE_TRI:  shape_d = tri_fold(theta);
      default:   shape_d = {AMP_W{theta[PH_W-1]}};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= {(TAIL+1){MID_C}};
    end else begin
      pipe[0] <= shape_d;
      for (int i = 1; i <= TAIL; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dac_code = pipe[TAIL];

endmodule

// File: rtl/dds_core.sv
module dds_core
  import dds_pkg::*;
#(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12,
  parameter int AMP_W = 10,
  parameter int SLOTS = 2,
  localparam int SEL_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wave_hold,
  input  logic             wr_freq_en,
  input  logic [SEL_W-1:0] wr_freq_idx,
  input  logic [ACC_W-1:0] wr_freq_word,
  input  logic             wr_phase_en,
  input  logic [SEL_W-1:0] wr_phase_idx,
  input  logic [PH_W-1:0]  wr_phase_word,
  input  logic [SEL_W-1:0] freq_sel,
  input  logic [SEL_W-1:0] phase_sel,
  input  logic [1:0]       wave_mode,
  output logic [AMP_W-1:0] dac_code
);

  // Three stages before the shaper plus TAIL retiming stages give a latency of 8.
  localparam int TAIL    = 5;
  localparam int LATENCY = 3 + TAIL;

  logic [SLOTS-1:0][ACC_W-1:0] freq_bank;
  logic [SLOTS-1:0][PH_W-1:0]  phase_bank;
  logic [ACC_W-1:0]            freq_act;
  logic [PH_W-1:0]             phase_act;
  logic [ACC_W-1:0]            acc_q;
  logic [PH_W-1:0]             theta_q;
  logic                        hold_sync;
  wave_e                       mode_al;

  dds_regbank #(.ACC_W(ACC_W), .PH_W(PH_W), .SLOTS(SLOTS)) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_freq_en   (wr_freq_en),
    .wr_freq_idx  (wr_freq_idx),
    .wr_freq_word (wr_freq_word),
    .wr_phase_en  (wr_phase_en),
    .wr_phase_idx (wr_phase_idx),
    .wr_phase_word(wr_phase_word),
    .freq_sel     (freq_sel),
    .phase_sel    (phase_sel),
    .freq_bank    (freq_bank),
    .phase_bank   (phase_bank),
    .freq_act     (freq_act),
    .phase_act    (phase_act)
  );

  dds_accum #(.ACC_W(ACC_W), .PH_W(PH_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_req (wave_hold),
    .freq_act (freq_act),
    .phase_act(phase_act),
    .mode_in  (wave_e'(wave_mode)),
    .acc_q    (acc_q),
    .theta_q  (theta_q),
    .mode_out (mode_al),
    .hold_sync(hold_sync)
  );

  dds_shaper #(.PH_W(PH_W), .AMP_W(AMP_W), .TAIL(TAIL)) u_shape (
    .clk     (clk),
    .rst_n   (rst_n),
    .theta   (theta_q),
    .mode    (mode_al),
    .dac_code(dac_code)
  );

endmodule

// File: rtl/dds_core_chk.sv
module dds_core_chk #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12,
  parameter int SLOTS = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wave_hold,
  input logic                        wr_freq_en,
  input logic                        wr_phase_en,
  input logic                        hold_sync,
  input logic [ACC_W-1:0]            acc_q,
  input logic [ACC_W-1:0]            freq_act,
  input logic [PH_W-1:0]             theta_q,
  input logic [SLOTS-1:0][ACC_W-1:0] freq_bank,
  input logic [SLOTS-1:0][PH_W-1:0]  phase_bank
);

  // R2: free-running advance by the active word, wrapping at the accumulator width
  assert_acc_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_sync |=> acc_q == ACC_W'($past(acc_q) + $past(freq_act)));

  // R5: hold parks the accumulator
  assert_hold_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_sync |=> acc_q == '0);

  // R5: hold puts the phase value at the waveform start
  assert_theta_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_sync |=> theta_q == '0);

  // R5: frequency words change only through their write port
  assert_freq_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_freq_en |=> $stable(freq_bank));

  // R5: phase words change only through their write port
  assert_phase_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_phase_en |=> $stable(phase_bank));

  // R6: hold reaches the accumulator stage two edges after sampling
  assert_hold_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wave_hold |=> ##1 hold_sync);

endmodule

bind dds_core dds_core_chk #(.ACC_W(ACC_W), .PH_W(PH_W), .SLOTS(SLOTS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wave_hold  (wave_hold),
  .wr_freq_en (wr_freq_en),
  .wr_phase_en(wr_phase_en),
  .hold_sync  (hold_sync),
  .acc_q      (acc_q),
  .freq_act   (freq_act),
  .theta_q    (theta_q),
  .freq_bank  (freq_bank),
  .phase_bank (phase_bank)
);

// File: tb/test_dds_core.sv
`timescale 1ns/1ps
module test_dds_core;

  localparam int ACC_W = 28;
  localparam int PH_W  = 12;
  localparam int AMP_W = 10;
  localparam int LAT   = 8;
  localparam int MIDV  = 512;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wave_hold = 1'b1;
  logic             wr_freq_en = 1'b0;
  logic             wr_freq_idx = 1'b0;
  logic [ACC_W-1:0] wr_freq_word = '0;
  logic             wr_phase_en = 1'b0;
  logic             wr_phase_idx = 1'b0;
  logic [PH_W-1:0]  wr_phase_word = '0;
  logic             freq_sel = 1'b0;
  logic             phase_sel = 1'b0;
  logic [1:0]       wave_mode = 2'd0;
  logic [AMP_W-1:0] dac_code;

  always #10 clk = ~clk;

  dds_core #(.ACC_W(ACC_W), .PH_W(PH_W), .AMP_W(AMP_W)) i_dds_core (
    .clk(clk), .rst_n(rst_n), .wave_hold(wave_hold),
    .wr_freq_en(wr_freq_en), .wr_freq_idx(wr_freq_idx), .wr_freq_word(wr_freq_word),
    .wr_phase_en(wr_phase_en), .wr_phase_idx(wr_phase_idx), .wr_phase_word(wr_phase_word),
    .freq_sel(freq_sel), .phase_sel(phase_sel), .wave_mode(wave_mode),
    .dac_code(dac_code)
  );

  int    n_chk = 0;
  int    n_err = 0;
  string cur_req = "R1";

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected code for phase value t, written straight from R7, R8 and R9
  function automatic int ref_code(int t, int m);
    real s;
    int  mag;
    if (m >= 2) return (t >= 2048) ? 1023 : 0;
    if (m == 1) return (t < 2048) ? (t >> 1) : ((4095 - t) >> 1);
    s   = $sin(2.0 * 3.141592653589793 * (real'(t) + 0.5) / 4096.0);
    mag = $rtoi(511.0 * (s < 0.0 ? -s : s) + 0.5);
    return (s >= 0.0) ? MIDV + mag : MIDV - mag;
  endfunction

  // Behavioural model: ideal result per edge, delayed LAT edges in a queue
  logic [ACC_W-1:0] m_freq [2];
  int               m_phase [2];
  logic [ACC_W-1:0] m_acc;
  bit               m_hold_prev;
  int               m_q [$];
  int               m_exp;
  bit               m_valid = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_freq[0] = '0; m_freq[1] = '0;
      m_phase[0] = 0; m_phase[1] = 0;
      m_acc = '0;
      m_hold_prev = 1'b1;
      m_q.delete();
      for (int i = 0; i < LAT; i++) m_q.push_back(MIDV);
      m_valid = 0;
    end else begin
      int t;
      if (wr_freq_en)  m_freq[wr_freq_idx]   = wr_freq_word;
      if (wr_phase_en) m_phase[wr_phase_idx] = int'(wr_phase_word);
      m_acc = m_hold_prev ? '0 : m_acc + m_freq[freq_sel];
      t = wave_hold ? 0 : (int'(m_acc >> (ACC_W - PH_W)) + m_phase[phase_sel]) % 4096;
      m_q.push_back(ref_code(t, int'(wave_mode)));
      m_exp = m_q.pop_front();
      m_valid = 1;
      m_hold_prev = wave_hold;
    end
  end

  always @(negedge clk) begin
    if (rst_n && m_valid) check(cur_req, int'(dac_code), m_exp);
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_freq(bit idx, logic [ACC_W-1:0] w);
    wr_freq_en = 1'b1; wr_freq_idx = idx; wr_freq_word = w;
    tick(1);
    wr_freq_en = 1'b0;
  endtask

  task automatic put_phase(bit idx, logic [PH_W-1:0] w);
    wr_phase_en = 1'b1; wr_phase_idx = idx; wr_phase_word = w;
    tick(1);
    wr_phase_en = 1'b0;
  endtask

  // Called one negedge after a change was applied; counts edges until the output moves
  task automatic count_latency(string req);
    int old;
    int n;
    old = int'(dac_code);
    n = 0;
    while (int'(dac_code) == old && n < 20) begin
      tick(1);
      n++;
    end
    check(req, n, LAT);
  endtask

  initial begin
    int v;
    // R1: reset state
    tick(3);
    check("R1", int'(dac_code), MIDV);
    tick(2);
    check("R1", int'(dac_code), MIDV);
    rst_n = 1'b1;
    tick(12);

    // R3: fill both banks while held
    cur_req = "R3";
    put_freq(1'b0, 28'h0100000);
    put_freq(1'b1, 28'h0345678);
    put_phase(1'b0, 12'h000);
    put_phase(1'b1, 12'h400);
    tick(12);

    // R2, R7: sine running from slot 0
    cur_req = "R7";
    wave_hold = 1'b0;
    tick(300);

    // R3, R4: switch slots
    cur_req = "R3";
    freq_sel = 1'b1;
    tick(200);
    cur_req = "R4";
    phase_sel = 1'b1;
    tick(200);

    // R8, R9: other shapes, including both square encodings
    cur_req = "R8";
    wave_mode = 2'd1;
    freq_sel = 1'b0;
    tick(300);
    cur_req = "R9";
    wave_mode = 2'd2;
    tick(200);
    wave_mode = 2'd3;
    tick(150);

    // R2: odd word on a long run
    cur_req = "R2";
    wave_mode = 2'd0;
    put_freq(1'b1, 28'h0ABCDEF);
    freq_sel = 1'b1;
    tick(400);

    // R11: near full-scale words wrap the accumulator
    cur_req = "R11";
    put_freq(1'b0, 28'hFF00000);
    freq_sel = 1'b0;
    tick(300);
    put_freq(1'b0, 28'hFFFFFFF);
    tick(100);

    // R10: zero word gives a constant output
    cur_req = "R10";
    put_freq(1'b0, 28'h0000000);
    tick(LAT + 4);
    v = int'(dac_code);
    for (int i = 0; i < 20; i++) begin
      tick(1);
      check("R10", int'(dac_code), v);
    end

    // R5: hold shows start code, keeps words, and writes during hold are retained
    cur_req = "R5";
    put_freq(1'b1, 28'h0200000);
    freq_sel = 1'b1;
    tick(50);
    wave_hold = 1'b1;
    tick(LAT + 4);
    check("R5", int'(dac_code), MIDV);
    put_phase(1'b1, 12'h123);
    tick(10);
    check("R5", int'(dac_code), MIDV);
    wave_mode = 2'd1;
    tick(LAT + 2);
    check("R5", int'(dac_code), 0);
    wave_mode = 2'd0;
    tick(LAT + 2);
    wave_hold = 1'b0;
    tick(300);

    // R6: latency after a phase write
    cur_req = "R6";
    freq_sel = 1'b0;
    phase_sel = 1'b0;
    put_phase(1'b0, 12'h000);
    tick(LAT + 4);
    wr_phase_en = 1'b1; wr_phase_idx = 1'b0; wr_phase_word = 12'h400;
    tick(1);
    wr_phase_en = 1'b0;
    count_latency("R6");

    // R6: latency after a frequency select change
    tick(LAT + 4);
    freq_sel = 1'b1;
    tick(1);
    count_latency("R6");

    // R6: latency after hold release (triangle, offset 0x200 gives code 256)
    wave_mode = 2'd1;
    freq_sel = 1'b0;
    put_phase(1'b0, 12'h200);
    wave_hold = 1'b1;
    tick(LAT + 4);
    check("R5", int'(dac_code), 0);
    wave_hold = 1'b0;
    tick(1);
    count_latency("R6");
    check("R6", int'(dac_code), 256);
    tick(20);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("Watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule